// File: doc/BRIEF.md
# Ingress Bus-Address Region Decoder

This block sits on the inbound request path of an I/O bridge. Each incoming read or write request carries a bus address. The block compares that address with a small table of programmable regions. Every region spans a whole number of 4 KB pages, starting on a 4 KB boundary. It carries a target base address, an address-space tag used by later translation, and one of several ordering disciplines. On a hit, the request leaves one cycle later with the translated target address, the region's tag and the region's index. A request that matches no region is consumed, dropped, and reported on a one-cycle miss pulse.

Ordering is enforced against transactions already in flight. Two counters track outstanding work: one counts writes, the other counts every transaction. A request is counted when it is accepted. A completion pulse, which carries a write/read flag, retires one transaction. Depending on the mode of the matched region, a request is held at the input until the counters allow it to pass. Regions are programmed through a single-cycle write port. A write whose alignment or length is illegal is refused, and the table is left unchanged.

Top module: `ingress_region_decoder`

## Requirements
- R1: A request whose page lies in `[start, start+len)` of an enabled region is accepted and appears on the response port on the next clock edge. Its address is `target + (req_addr - start)`, with the region's tag and index, and the end of the range is exclusive.
- R2: When several enabled regions match, the one with the lowest index is used. A region written with enable 0 no longer matches.
- R3: A request that matches no enabled region is accepted without delay. It produces no response, and `miss_flag` is high for exactly the cycle after acceptance.
- R4: A configuration write is refused in any of these cases: the start, length or target has any of bits [11:0] set, the length is zero, or the index is not below the region count. A refused write gives `cfg_err`=1 on the cycle after the write, and the region table is unchanged. A legal write gives `cfg_err`=0 and takes effect for requests from the next cycle on.
- R5: In the loose mode (`cfg_mode`=0), writes are never held for ordering. Reads are held while any accepted write is still outstanding.
- R6: In the strict mode (`cfg_mode`=1, and also code 3), every request is held while any accepted transaction is still outstanding.
- R7: In the packet-directed mode (`cfg_mode`=2), reads and writes with `req_relaxed`=0 are held while any write is outstanding. Writes with `req_relaxed`=1 are not held.
- R8: Each accepted hit adds one to the outstanding counts. A completion with `cpl_write`=1 retires one write, and with `cpl_write`=0 it retires one read. A completion that finds no matching outstanding transaction is ignored, so counts never underflow. Intake stalls if the all-transaction counter is full.
- R9: While `rsp_valid`=1 and `rsp_ready`=0, the response holds its values and no new request is accepted.
- R10: After reset, no region is enabled, both counts are zero, `rsp_valid`, `miss_flag` and `cfg_err` are 0, and every request misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Region table write strobe |
| cfg_idx | input | IDX_W | Region index being written |
| cfg_en | input | 1 | Region enable |
| cfg_start | input | ADDR_W | Region start bus address (4 KB aligned) |
| cfg_len | input | ADDR_W | Region length in bytes (non-zero multiple of 4 KB) |
| cfg_target | input | ADDR_W | Target base address (4 KB aligned) |
| cfg_tag | input | TAG_W | Address-space tag |
| cfg_mode | input | 2 | Ordering mode: 0 loose, 1 strict, 2 packet-directed, 3 strict |
| cfg_err | output | 1 | Pulse: previous configuration write refused |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_addr | input | ADDR_W | Request bus address |
| req_write | input | 1 | 1 write, 0 read |
| req_relaxed | input | 1 | Relaxed-ordering attribute of the request |
| rsp_valid | output | 1 | Translated request valid |
| rsp_ready | input | 1 | Downstream accepts response |
| rsp_addr | output | ADDR_W | Translated target address |
| rsp_write | output | 1 | Request direction |
| rsp_tag | output | TAG_W | Address-space tag of matched region |
| rsp_region | output | IDX_W | Index of matched region |
| miss_flag | output | 1 | Pulse: a request matched no region and was dropped |
| cpl_valid | input | 1 | Completion pulse for one outstanding transaction |
| cpl_write | input | 1 | Completion is for a write (1) or read (0) |

## Verification
On every cycle, the assertions check the ordering gate at the moment a request is accepted. No read gets through in loose mode while a write is outstanding. No strict request gets through while anything is outstanding. No ordered write gets through in packet mode while a write is outstanding. The assertions also check that the selected region is the lowest matching one, that a refused configuration write leaves the table untouched, that the counters move by at most one and keep writes within the total, and that a stalled response holds still. The bench scenarios are needed to show the translated address values, the exclusive end of each range, the disabling of a region, and the way the counters are drained by completions. They also show that a refused write really leaves a page unmapped and that completions arriving at zero are ignored.

// File: rtl/ird_pkg.sv
// Package: shared constants and the ordering-mode encoding for the region decoder.
// Assumes 4 KB pages; the page shift is fixed by the addressing scheme.
package ird_pkg;
    localparam int PAGE_SHIFT = 12;

    typedef enum logic [1:0] {
        ORD_LOOSE  = 2'd0,
        ORD_STRICT = 2'd1,
        ORD_PKT    = 2'd2,
        ORD_RSVD   = 2'd3
    } ord_mode_e;
endpackage

// File: rtl/ird_region_table.sv
// Region table: holds NREG programmable regions in page units.
// Validates each configuration write (alignment, non-zero length, index range),
// refuses illegal ones with a one-cycle error pulse, and stores the exclusive
// end page precomputed so the matcher needs no adder.
// Assumes cfg_* are stable during the cycle cfg_we is high.
module ird_region_table #(
    parameter int NREG   = 4,
    parameter int ADDR_W = 32,
    parameter int TAG_W  = 4,
    localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1,
    localparam int PG_W  = ADDR_W - ird_pkg::PAGE_SHIFT
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_we,
    input  logic [IDX_W-1:0]             cfg_idx,
    input  logic                         cfg_en,
    input  logic [ADDR_W-1:0]            cfg_start,
    input  logic [ADDR_W-1:0]            cfg_len,
    input  logic [ADDR_W-1:0]            cfg_target,
    input  logic [TAG_W-1:0]             cfg_tag,
    input  logic [1:0]                   cfg_mode,
    output logic                         cfg_err,
    output logic [NREG-1:0]              en_o,
    output logic [NREG-1:0][PG_W-1:0]    start_pg_o,
    output logic [NREG-1:0][PG_W:0]      end_pg_o,
    output logic [NREG-1:0][PG_W-1:0]    tgt_pg_o,
    output logic [NREG-1:0][TAG_W-1:0]   tag_o,
    output logic [NREG-1:0][1:0]         mode_o
);
    localparam int PS = ird_pkg::PAGE_SHIFT;

    logic          bad_wr;
    logic          good_wr;
    logic [PG_W:0] end_pg_new;

    // Decide whether the incoming configuration write is legal.
    always_comb begin
        bad_wr = (|cfg_start[PS-1:0]) || (|cfg_len[PS-1:0]) || (|cfg_target[PS-1:0])
              || (cfg_len == '0)
              || ({1'b0, cfg_idx} >= (IDX_W+1)'(NREG));
        good_wr    = cfg_we && !bad_wr;
        end_pg_new = {1'b0, cfg_start[ADDR_W-1:PS]} + {1'b0, cfg_len[ADDR_W-1:PS]};
    end

    // Register the refusal pulse for the cycle after the write.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_err <= 1'b0;
        else        cfg_err <= cfg_we && bad_wr;
    end

    // One storage slot per region, written only by a legal write to its index.
    for (genvar g = 0; g < NREG; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_o[g]       <= 1'b0;
                start_pg_o[g] <= '0;
                end_pg_o[g]   <= '0;
                tgt_pg_o[g]   <= '0;
                tag_o[g]      <= '0;
                mode_o[g]     <= '0;
            end else if (good_wr && (cfg_idx == IDX_W'(g))) begin
                en_o[g]       <= cfg_en;
                start_pg_o[g] <= cfg_start[ADDR_W-1:PS];
                end_pg_o[g]   <= end_pg_new;
                tgt_pg_o[g]   <= cfg_target[ADDR_W-1:PS];
                tag_o[g]      <= cfg_tag;
                mode_o[g]     <= cfg_mode;
            end
        end
    end

    // A refused write must not have disturbed any stored field (R4).
    assert_reject_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> ($stable(en_o) && $stable(start_pg_o) && $stable(end_pg_o)
                     && $stable(tgt_pg_o) && $stable(tag_o) && $stable(mode_o)));
endmodule

// File: rtl/ird_match.sv
// Region matcher: compares one request page against every region in parallel
// and picks the lowest-index enabled hit. Purely combinational.
// Assumes end pages are exclusive and carry one extra bit for the top of space.
module ird_match #(
    parameter int NREG   = 4,
    parameter int ADDR_W = 32,
    parameter int TAG_W  = 4,
    localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1,
    localparam int PG_W  = ADDR_W - ird_pkg::PAGE_SHIFT
) (
    input  logic [PG_W-1:0]              pg,
    input  logic [NREG-1:0]              en_i,
    input  logic [NREG-1:0][PG_W-1:0]    start_pg_i,
    input  logic [NREG-1:0][PG_W:0]      end_pg_i,
    input  logic [NREG-1:0][PG_W-1:0]    tgt_pg_i,
    input  logic [NREG-1:0][TAG_W-1:0]   tag_i,
    input  logic [NREG-1:0][1:0]         mode_i,
    output logic [NREG-1:0]              hit_vec,
    output logic                         hit,
    output logic [IDX_W-1:0]             sel_idx,
    output logic [PG_W-1:0]              sel_start_pg,
    output logic [PG_W-1:0]              sel_tgt_pg,
    output logic [TAG_W-1:0]             sel_tag,
    output logic [1:0]                   sel_mode
);
    // Per-region range compare, one comparator pair per slot.
    for (genvar g = 0; g < NREG; g++) begin : g_cmp
        assign hit_vec[g] = en_i[g] && (pg >= start_pg_i[g]) && ({1'b0, pg} < end_pg_i[g]);
    end

    // Priority select: scanning downward leaves the lowest hit index.
    always_comb begin
        hit     = 1'b0;
        sel_idx = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                hit     = 1'b1;
                sel_idx = IDX_W'(i);
            end
        end
    end

    // Route the chosen region's parameters.
    always_comb begin
        sel_start_pg = start_pg_i[sel_idx];
        sel_tgt_pg   = tgt_pg_i[sel_idx];
        sel_tag      = tag_i[sel_idx];
        sel_mode     = mode_i[sel_idx];
    end
endmodule

// File: rtl/ird_order_gate.sv
// Ordering gate: keeps an outstanding-write count and an outstanding-any count,
// and decides whether the request at the input must wait for earlier work,
// according to the ordering mode of its region.
// Assumes a completion is only signalled for a transaction already accepted;
// stray completions are ignored.
module ird_order_gate #(
    parameter int CNT_W = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                inc,
    input  logic                inc_write,
    input  logic                cpl_valid,
    input  logic                cpl_write,
    input  ird_pkg::ord_mode_e  mode,
    input  logic                is_write,
    input  logic                relaxed,
    output logic                stall,
    output logic [CNT_W-1:0]    wr_cnt,
    output logic [CNT_W-1:0]    any_cnt
);
    import ird_pkg::*;

    logic [CNT_W-1:0] wr_nxt;
    logic [CNT_W-1:0] any_nxt;
    logic             wr_busy;
    logic             any_busy;

    // Ordering rule per mode; a full counter also blocks intake.
    always_comb begin
        wr_busy  = (wr_cnt != '0);
        any_busy = (any_cnt != '0);
        unique case (mode)
            ORD_LOOSE: stall = !is_write && wr_busy;
            ORD_PKT:   stall = (!is_write || !relaxed) && wr_busy;
            default:   stall = any_busy;
        endcase
        if (&any_cnt) stall = 1'b1;
    end

    // Next counts: add accepted work, retire completions that match something.
    always_comb begin
        wr_nxt  = wr_cnt;
        any_nxt = any_cnt;
        if (inc) begin
            any_nxt = any_nxt + CNT_W'(1);
            if (inc_write) wr_nxt = wr_nxt + CNT_W'(1);
        end
        if (cpl_valid) begin
            if (cpl_write) begin
                if (wr_cnt != '0) begin
                    wr_nxt  = wr_nxt - CNT_W'(1);
                    any_nxt = any_nxt - CNT_W'(1);
                end
            end else if (any_cnt > wr_cnt) begin
                any_nxt = any_nxt - CNT_W'(1);
            end
        end
    end

    // Counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_cnt  <= '0;
            any_cnt <= '0;
        end else begin
            wr_cnt  <= wr_nxt;
            any_cnt <= any_nxt;
        end
    end

    // Counts move by at most one per cycle and writes never exceed the total (R8).
    assert_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (any_cnt == $past(any_cnt)) || (any_cnt == $past(any_cnt) + CNT_W'(1))
        || (any_cnt == $past(any_cnt) - CNT_W'(1)));
    assert_wr_within_any_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt <= any_cnt);
endmodule

// File: rtl/ingress_region_decoder.sv
// Ingress region decoder top: matches each request address against the region
// table, enforces the matched region's ordering rule, and emits the translated
// request through a one-deep output register. Misses are dropped with a pulse.
// Assumes downstream follows valid/ready and completions refer to emitted work.
module ingress_region_decoder #(
    parameter int NREG   = 4,
    parameter int ADDR_W = 32,
    parameter int TAG_W  = 4,
    parameter int CNT_W  = 6,
    localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic              cfg_en,
    input  logic [ADDR_W-1:0] cfg_start,
    input  logic [ADDR_W-1:0] cfg_len,
    input  logic [ADDR_W-1:0] cfg_target,
    input  logic [TAG_W-1:0]  cfg_tag,
    input  logic [1:0]        cfg_mode,
    output logic              cfg_err,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_relaxed,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic              rsp_write,
    output logic [TAG_W-1:0]  rsp_tag,
    output logic [IDX_W-1:0]  rsp_region,
    output logic              miss_flag,
    input  logic              cpl_valid,
    input  logic              cpl_write
);
    import ird_pkg::*;
    localparam int PS   = PAGE_SHIFT;
    localparam int PG_W = ADDR_W - PS;

    logic [NREG-1:0]            t_en;
    logic [NREG-1:0][PG_W-1:0]  t_start;
    logic [NREG-1:0][PG_W:0]    t_end;
    logic [NREG-1:0][PG_W-1:0]  t_tgt;
    logic [NREG-1:0][TAG_W-1:0] t_tag;
    logic [NREG-1:0][1:0]       t_mode;

    logic [NREG-1:0]  hit_vec;
    logic             hit;
    logic [IDX_W-1:0] sel_idx;
    logic [PG_W-1:0]  sel_start_pg;
    logic [PG_W-1:0]  sel_tgt_pg;
    logic [TAG_W-1:0] sel_tag;
    logic [1:0]       sel_mode;
    ord_mode_e        sel_ord;

    logic             stall;
    logic [CNT_W-1:0] wr_cnt;
    logic [CNT_W-1:0] any_cnt;
    logic             slot_free;
    logic             accept;
    logic             take_hit;
    logic [PG_W-1:0]  xlat_pg;

    ird_region_table #(.NREG(NREG), .ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_table (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en),
        .cfg_start(cfg_start), .cfg_len(cfg_len), .cfg_target(cfg_target),
        .cfg_tag(cfg_tag), .cfg_mode(cfg_mode), .cfg_err(cfg_err),
        .en_o(t_en), .start_pg_o(t_start), .end_pg_o(t_end),
        .tgt_pg_o(t_tgt), .tag_o(t_tag), .mode_o(t_mode)
    );

    ird_match #(.NREG(NREG), .ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_match (
        .pg(req_addr[ADDR_W-1:PS]),
        .en_i(t_en), .start_pg_i(t_start), .end_pg_i(t_end),
        .tgt_pg_i(t_tgt), .tag_i(t_tag), .mode_i(t_mode),
        .hit_vec(hit_vec), .hit(hit), .sel_idx(sel_idx),
        .sel_start_pg(sel_start_pg), .sel_tgt_pg(sel_tgt_pg),
        .sel_tag(sel_tag), .sel_mode(sel_mode)
    );

    assign sel_ord = ord_mode_e'(sel_mode);

    ird_order_gate #(.CNT_W(CNT_W)) u_gate (
        .clk(clk), .rst_n(rst_n),
        .inc(take_hit), .inc_write(req_write),
        .cpl_valid(cpl_valid), .cpl_write(cpl_write),
        .mode(sel_ord), .is_write(req_write), .relaxed(req_relaxed),
        .stall(stall), .wr_cnt(wr_cnt), .any_cnt(any_cnt)
    );

    // Intake handshake: output slot must be free, and a hit must pass the gate.
    always_comb begin
        slot_free = !rsp_valid || rsp_ready;
        req_ready = slot_free && (!hit || !stall);
        accept    = req_valid && req_ready;
        take_hit  = accept && hit;
        xlat_pg   = sel_tgt_pg + (req_addr[ADDR_W-1:PS] - sel_start_pg);
    end

    // Output register and miss pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_addr   <= '0;
            rsp_write  <= 1'b0;
            rsp_tag    <= '0;
            rsp_region <= '0;
            miss_flag  <= 1'b0;
        end else begin
            miss_flag <= accept && !hit;
            if (slot_free) rsp_valid <= take_hit;
            if (take_hit) begin
                rsp_addr   <= {xlat_pg, req_addr[PS-1:0]};
                rsp_write  <= req_write;
                rsp_tag    <= sel_tag;
                rsp_region <= sel_idx;
            end
        end
    end

    // Chosen region has no lower-index match (R2).
    assert_lowest_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && hit) |-> ((hit_vec & ((NREG'(1) << sel_idx) - NREG'(1))) == '0));
    // A dropped request produces no response (R3).
    assert_miss_no_rsp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        miss_flag |-> !rsp_valid);
    // Loose mode: no read enters while a write is outstanding (R5).
    assert_loose_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (take_hit && sel_ord == ORD_LOOSE && !req_write) |-> (wr_cnt == '0));
    // Strict mode: nothing enters while anything is outstanding (R6).
    assert_strict_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (take_hit && (sel_ord == ORD_STRICT || sel_ord == ORD_RSVD)) |-> (any_cnt == '0));
    // Packet mode: ordered requests do not pass outstanding writes (R7).
    assert_pkt_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (take_hit && sel_ord == ORD_PKT && !(req_write && req_relaxed)) |-> (wr_cnt == '0));
    // A stalled response keeps its contents (R9).
    assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) && $stable(rsp_tag)
                                       && $stable(rsp_region) && $stable(rsp_write)));
endmodule

// File: tb/ingress_region_decoder_tb.sv
`timescale 1ns/1ps
module ingress_region_decoder_tb;
    localparam int NREG = 4;
    localparam int AW   = 32;
    localparam int TW   = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 0, cfg_en = 0;
    logic [1:0]    cfg_idx = 0;
    logic [AW-1:0] cfg_start = 0, cfg_len = 0, cfg_target = 0;
    logic [TW-1:0] cfg_tag = 0;
    logic [1:0]    cfg_mode = 0;
    logic          cfg_err;
    logic          req_valid = 0, req_write = 0, req_relaxed = 0;
    logic          req_ready;
    logic [AW-1:0] req_addr = 0;
    logic          rsp_valid, rsp_write, miss_flag;
    logic          rsp_ready = 1;
    logic [AW-1:0] rsp_addr;
    logic [TW-1:0] rsp_tag;
    logic [1:0]    rsp_region;
    logic          cpl_valid = 0, cpl_write = 0;

    always #2.5 clk = ~clk;

    ingress_region_decoder #(.NREG(NREG), .ADDR_W(AW), .TAG_W(TW), .CNT_W(6)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en), .cfg_start(cfg_start),
        .cfg_len(cfg_len), .cfg_target(cfg_target), .cfg_tag(cfg_tag), .cfg_mode(cfg_mode),
        .cfg_err(cfg_err),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_relaxed(req_relaxed),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr),
        .rsp_write(rsp_write), .rsp_tag(rsp_tag), .rsp_region(rsp_region),
        .miss_flag(miss_flag), .cpl_valid(cpl_valid), .cpl_write(cpl_write)
    );

    int total = 0, bad = 0, cyc = 0;
    int wcnt = 0, acnt = 0;
    bit last_miss;
    bit          m_en[NREG];
    longint      m_start[NREG], m_len[NREG], m_tgt[NREG];
    int          m_tag[NREG], m_mode[NREG];

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic int find_region(input longint a);
        for (int i = 0; i < NREG; i++)
            if (m_en[i] && a >= m_start[i] && a < m_start[i] + m_len[i]) return i;
        return -1;
    endfunction

    function automatic bit must_stall(input int r, input bit wr, input bit rel);
        case (m_mode[r])
            0:       return !wr && wcnt != 0;
            2:       return (!wr || !rel) && wcnt != 0;
            default: return acnt != 0;
        endcase
    endfunction

    function automatic string mode_req(input int r);
        case (m_mode[r])
            0:       return "R5";
            2:       return "R7";
            default: return "R6";
        endcase
    endfunction

    task automatic cfg_write(input int idx, input bit en, input longint st, input longint ln,
                             input longint tg, input int tag, input int mode);
        bit exp_bad;
        exp_bad = (st % 4096 != 0) || (ln % 4096 != 0) || (tg % 4096 != 0) || (ln == 0);
        @(negedge clk);
        cfg_we = 1; cfg_idx = 2'(idx); cfg_en = en; cfg_start = AW'(st); cfg_len = AW'(ln);
        cfg_target = AW'(tg); cfg_tag = TW'(tag); cfg_mode = 2'(mode);
        @(negedge clk);
        cfg_we = 0;
        #1;
        chk(cfg_err == exp_bad, "R4", "cfg_err", cfg_err, exp_bad);
        if (!exp_bad) begin
            m_en[idx] = en; m_start[idx] = st; m_len[idx] = ln; m_tgt[idx] = tg;
            m_tag[idx] = tag; m_mode[idx] = mode;
        end
    endtask

    task automatic complete_one();
        bit w;
        if (wcnt > 0) w = 1;
        else if (acnt > 0) w = 0;
        else return;
        @(negedge clk); cpl_valid = 1; cpl_write = w;
        @(negedge clk); cpl_valid = 0;
        acnt--; if (w) wcnt--;
    endtask

    task automatic drain();
        while (acnt > 0) complete_one();
    endtask

    task automatic do_req(input longint a, input bit wr, input bit rel);
        int r;
        longint ea;
        r = find_region(a);
        @(negedge clk);
        req_valid = 1; req_addr = AW'(a); req_write = wr; req_relaxed = rel;
        #1;
        if (r >= 0 && must_stall(r, wr, rel)) begin
            for (int k = 0; k < 2; k++) begin
                chk(req_ready == 0, mode_req(r), "held ready", req_ready, 0);
                @(negedge clk); #1;
            end
            while (must_stall(r, wr, rel)) complete_one();
            #1;
        end
        chk(req_ready == 1, (r >= 0) ? mode_req(r) : "R3", "ready", req_ready, 1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        #1;
        last_miss = miss_flag;
        if (r >= 0) begin
            ea = (m_tgt[r] + (a - m_start[r])) & 64'hFFFF_FFFF;
            chk(rsp_valid == 1, "R1", "rsp_valid", rsp_valid, 1);
            chk(rsp_addr == AW'(ea), "R1", "rsp_addr", rsp_addr, ea);
            chk(rsp_tag == TW'(m_tag[r]) && rsp_write == wr, "R1", "tag", rsp_tag, m_tag[r]);
            chk(rsp_region == 2'(r), "R2", "region", rsp_region, r);
            acnt++; if (wr) wcnt++;
        end else begin
            chk(miss_flag == 1 && rsp_valid == 0, "R3", "miss", {miss_flag, rsp_valid}, 2);
        end
    endtask

    initial begin
        longint held;
        void'($urandom(32'd1234));
        for (int i = 0; i < NREG; i++) begin
            m_en[i] = 0; m_start[i] = 0; m_len[i] = 0; m_tgt[i] = 0; m_tag[i] = 0; m_mode[i] = 0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1;
        #1;
        // Reset state (R10)
        chk(rsp_valid == 0 && miss_flag == 0 && cfg_err == 0, "R10", "outputs",
            {rsp_valid, miss_flag, cfg_err}, 0);
        chk(req_ready == 1, "R10", "ready", req_ready, 1);
        do_req(64'h1000, 1, 0);
        chk(last_miss == 1, "R10", "empty table miss", last_miss, 1);

        // Legal programming: r0 loose, r1 strict overlapping r0, r2 packet mode
        cfg_write(0, 1, 64'h1000, 64'h2000, 64'h8000_0000, 1, 0);
        cfg_write(1, 1, 64'h2000, 64'h3000, 64'h4000_0000, 2, 1);
        cfg_write(2, 1, 64'h10000, 64'h1000, 64'h123000, 3, 2);

        // Refused programming leaves slot 3 empty (R4)
        cfg_write(3, 1, 64'h20800, 64'h4000, 64'h0, 5, 3);
        cfg_write(3, 1, 64'h20000, 64'h1800, 64'h0, 5, 3);
        cfg_write(3, 1, 64'h20000, 64'h4000, 64'h10, 5, 3);
        cfg_write(3, 1, 64'h20000, 64'h0, 64'h0, 5, 3);
        do_req(64'h20000, 0, 0);
        chk(last_miss == 1, "R4", "refused slot unmapped", last_miss, 1);
        cfg_write(3, 1, 64'h20000, 64'h4000, 64'hF000_0000, 5, 3);

        // Priority and disable (R2)
        do_req(64'h2800, 0, 0);
        cfg_write(0, 0, 64'h1000, 64'h2000, 64'h8000_0000, 1, 0);
        do_req(64'h2800, 0, 0);
        drain();
        cfg_write(0, 1, 64'h1000, 64'h2000, 64'h8000_0000, 1, 0);

        // Range edges, end exclusive (R1)
        do_req(64'h2FFF, 0, 0);
        do_req(64'h4FFF, 0, 0);
        do_req(64'h5000, 0, 0);
        do_req(64'h23ABC, 0, 0);
        drain();

        // Loose mode (R5): writes pass writes, read waits
        do_req(64'h1100, 1, 0);
        do_req(64'h1200, 1, 0);
        do_req(64'h1300, 0, 0);
        drain();

        // Strict mode (R6)
        do_req(64'h3000, 0, 0);
        do_req(64'h3004, 1, 0);
        do_req(64'h3008, 0, 0);
        drain();

        // Packet mode (R7)
        do_req(64'h10010, 1, 0);
        do_req(64'h10020, 1, 1);
        do_req(64'h10030, 1, 0);
        do_req(64'h10040, 0, 1);
        drain();

        // Stray completions at zero are ignored (R8)
        @(negedge clk); cpl_valid = 1; cpl_write = 1;
        @(negedge clk); cpl_write = 0;
        @(negedge clk); cpl_valid = 0;
        req_valid = 1; req_addr = 32'h3000; req_write = 0; req_relaxed = 0;
        #1;
        chk(req_ready == 1, "R8", "no underflow", req_ready, 1);
        @(negedge clk); req_valid = 0; acnt++;
        // One read outstanding: a write completion must not retire it (R8)
        @(negedge clk); cpl_valid = 1; cpl_write = 1;
        @(negedge clk); cpl_valid = 0;
        req_valid = 1; req_addr = 32'h3000;
        #1;
        chk(req_ready == 0, "R8", "read still counted", req_ready, 0);
        @(negedge clk); req_valid = 0;
        drain();

        // Back-pressure (R9)
        @(negedge clk);
        rsp_ready = 0;
        req_valid = 1; req_addr = 32'h1000; req_write = 1; req_relaxed = 0;
        @(negedge clk);
        req_addr = 32'h1004;
        #1;
        held = rsp_addr;
        chk(rsp_valid == 1 && rsp_addr == 32'h8000_0000, "R9", "first rsp", rsp_addr, 64'h8000_0000);
        chk(req_ready == 0, "R9", "intake blocked", req_ready, 0);
        @(negedge clk); #1;
        chk(rsp_valid == 1 && rsp_addr == AW'(held), "R9", "held addr", rsp_addr, held);
        rsp_ready = 1;
        @(negedge clk); req_valid = 0; #1;
        chk(rsp_valid == 1 && rsp_addr == 32'h8000_0004, "R9", "second rsp", rsp_addr, 64'h8000_0004);
        acnt += 2; wcnt += 2;
        drain();

        // Constrained random traffic over all regions and modes (R1, R2, R3, R5, R6, R7)
        for (int n = 0; n < 400; n++) begin
            longint a;
            a = (longint'($urandom % 38) << 12) | longint'($urandom % 4096);
            do_req(a, 1'($urandom % 2), 1'($urandom % 2));
            if (($urandom % 2) == 0 || acnt > 20) complete_one();
        end
        drain();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule